// File: doc/BRIEF.md
# Performance Event Counter Unit

This block tallies activity inside a processor core for profiling software. It holds one free-running cycle counter of 64 bits and a parameterised number of 32-bit event counters. Each event counter is programmed with an event code and with privilege-level filter bits. Event pulses arrive as a small vector of strobes, each tagged with the privilege level that was current when it occurred. Software can also advance chosen counters through an increment register.

Software programs the unit over a simple word-addressed register bus. A write takes effect at the clock edge that captures it. Read data and the access-error pulse appear one cycle after the request. Each counter that wraps raises a flag in an overflow register, and these flags are cleared by writing 1 to them. The flags are gated by per-counter interrupt enables and combined into one registered interrupt line.

An access from privilege level 0 passes only when a user-permission register allows it. A denied access reads zero, leaves all state unchanged, and pulses an error output.

Top module: `pmu_core`

## Requirements
- R1: After reset every stored register and counter is zero, `irq_o` and `err_o` are low, and a read of the control register (address 0x00) returns NUM_EVT in bits 15:11 with all other bits zero.
- R2: A control write keeps bits 0 (global enable), 3 (cycle divide), 4, 5 and 6 (64-bit cycle overflow). Bits 1 and 2 are action bits and read back as 0. Bits 15:11 are read-only.
- R3: Event counter i (type at 0x20+i, value at 0x40+i) advances by one at a clock edge only when control bit 0 and count-enable bit i (address 0x01) are both set. Codes select events as follows: 0x03 uses `evt_stb_i[0]`, 0x04 uses `[1]`, 0x10 uses `[2]`, 0x12 uses `[3]`, 0x11 counts every cycle, and any other code except 0x00 never counts.
- R4: A non-software event is counted only when its level passes the filter. Level 0 passes unless type bit 30 is set. Level 1 passes unless bit 31 is set. Level 2 passes only if bit 27 is set. Level 3 never passes.
- R5: A write to an event type register keeps only the bits in 0xC800FFFF.
- R6: With event code 0x00, a counter advances once for each accepted write to the increment register (0x04) that has a 1 in that counter's bit position.
- R7: Writing control bit 1 as 1 clears all event counters. Writing control bit 2 as 1 clears the cycle counter and its prescaler.
- R8: The cycle counter (low word 0x06, high word 0x07) advances on every cycle while control bit 0 and count-enable bit 31 are set. When control bit 3 is also set, it advances once every 64 enabled cycles.
- R9: With control bit 6 clear, overflow bit 31 is set when the low 32 bits of the cycle counter wrap. With bit 6 set, it is set only when the full 64-bit value wraps.
- R10: Overflow bit i (address 0x03) is set when event counter i wraps from all ones to zero. Writing 1 to a bit clears it.
- R11: `irq_o` is high one cycle after any overflow bit is set whose interrupt-enable bit (address 0x02) is also set, and it drops once no such pair remains.
- R12: The user-permission register (0x05) governs level-0 access. Bit 0 allows every access. Bit 1 allows writes to the increment register. Bit 2 allows reads of the cycle counter. Bit 3 allows reads of the event counters. A denied access returns 0, changes nothing, and pulses `err_o` high for one cycle.
- R13: Read data appears one cycle after the request. Unmapped addresses, including type and counter slots at or above NUM_EVT, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_lvl_i | input | 2 | Privilege level of the access |
| evt_stb_i | input | 4 | Event strobes: refill, access, mispredict, predicted |
| evt_lvl_i | input | 2 | Privilege level tagging the strobes |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse on a denied access |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the unit with four event counters rather than the default six. This makes the type and counter slots from 4 upward unmapped, so the zero-read path for them can be checked. It also shows that the reported counter count in the control register follows the parameter. Random bursts of strobes at random levels, with random codes, filters and enables, are compared against a bench model. Directed sequences cover wrap of the low 32 bits against wrap of the full 64 bits, the divide-by-64 tick boundary after 130 enabled cycles, and every user-permission case.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int STB_W  = 4;
  localparam int LVL_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CNTEN = 8'h01;
  localparam logic [ADDR_W-1:0] A_INTEN = 8'h02;
  localparam logic [ADDR_W-1:0] A_OVF   = 8'h03;
  localparam logic [ADDR_W-1:0] A_SWINC = 8'h04;
  localparam logic [ADDR_W-1:0] A_USREN = 8'h05;
  localparam logic [ADDR_W-1:0] A_CYCLO = 8'h06;
  localparam logic [ADDR_W-1:0] A_CYCHI = 8'h07;
  localparam logic [ADDR_W-1:0] A_TYPE0 = 8'h20;
  localparam logic [ADDR_W-1:0] A_CNT0  = 8'h40;

  localparam logic [DATA_W-1:0] TYPE_KEEP = 32'hC800_FFFF;

  localparam logic [15:0] EV_SWINC   = 16'h0000;
  localparam logic [15:0] EV_REFILL  = 16'h0003;
  localparam logic [15:0] EV_ACCESS  = 16'h0004;
  localparam logic [15:0] EV_MISPRED = 16'h0010;
  localparam logic [15:0] EV_CYCLES  = 16'h0011;
  localparam logic [15:0] EV_PRED    = 16'h0012;

  localparam int T_NO_L1 = 31;
  localparam int T_NO_L0 = 30;
  localparam int T_L2    = 27;

  // filter decision for one privilege level
  function automatic logic level_ok(input logic [DATA_W-1:0] t, input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    return !t[T_NO_L0];
      2'd1:    return !t[T_NO_L1];
      2'd2:    return t[T_L2];
      default: return 1'b0;
    endcase
  endfunction

  // one-cycle hit for a counter programmed with type t
  function automatic logic event_hit(input logic [DATA_W-1:0] t, input logic [STB_W-1:0] stb,
                                     input logic [LVL_W-1:0] lvl, input logic sw);
    logic sel;
    case (t[15:0])
      EV_REFILL:  sel = stb[0];
      EV_ACCESS:  sel = stb[1];
      EV_MISPRED: sel = stb[2];
      EV_PRED:    sel = stb[3];
      EV_CYCLES:  sel = 1'b1;
      default:    sel = 1'b0;
    endcase
    if (t[15:0] == EV_SWINC) return sw;
    return sel & level_ok(t, lvl);
  endfunction
endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [DATA_W-1:0]   type_i,
  input  logic [STB_W-1:0]    stb_i,
  input  logic [LVL_W-1:0]    lvl_i,
  input  logic                sw_i,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    val_o,
  output logic                wrap_o
);
  logic [CNT_W-1:0] val_q;
  logic             bump;

  assign bump   = en_i & event_hit(type_i, stb_i, lvl_i, sw_i);
  assign wrap_o = bump & ~clr_i & ~wr_i & (&val_q);
  assign val_o  = val_q;

  // clear beats a write, a write beats an increment
  always_ff @(posedge clk) begin
    if (rst)        val_q <= '0;
    else if (clr_i) val_q <= '0;
    else if (wr_i)  val_q <= wdata_i;
    else if (bump)  val_q <= val_q + 1'b1;
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i && !wr_i) |=> $stable(val_q));

  // R7
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (val_q == '0));
endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter
  import pmu_pkg::*;
#(
  parameter int CYC_W = 64,
  parameter int PRE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               div_i,
  input  logic               long_i,
  input  logic               clr_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [CYC_W-1:0]   val_o,
  output logic               wrap_o
);
  localparam int HALF = CYC_W / 2;

  logic [CYC_W-1:0] val_q;
  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic             any_wr;

  assign tick   = en_i & (~div_i | (&pre_q));
  assign any_wr = wr_lo_i | wr_hi_i;
  assign wrap_o = tick & ~clr_i & ~any_wr & (long_i ? (&val_q) : (&val_q[HALF-1:0]));
  assign val_o  = val_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) pre_q <= '0;
    else if (en_i)    pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      val_q <= '0;
    end else if (any_wr) begin
      if (wr_lo_i) val_q[HALF-1:0]     <= wdata_i[HALF-1:0];
      if (wr_hi_i) val_q[CYC_W-1:HALF] <= wdata_i[HALF-1:0];
    end else if (tick) begin
      val_q <= val_q + 1'b1;
    end
  end

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && div_i && !(&pre_q) && !clr_i && !any_wr) |=> $stable(val_q));
endmodule

// File: rtl/pmu_regbus.sv
module pmu_regbus
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_en_i,
  input  logic                           bus_we_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic [DATA_W-1:0]              bus_wdata_i,
  input  logic [LVL_W-1:0]               bus_lvl_i,
  input  logic [NUM_EVT-1:0][DATA_W-1:0] evt_val_i,
  input  logic [2*DATA_W-1:0]            cyc_val_i,
  input  logic [DATA_W-1:0]              ovf_set_i,
  output logic [6:0]                     ctrl_o,
  output logic [DATA_W-1:0]              cnten_o,
  output logic [NUM_EVT-1:0][DATA_W-1:0] type_o,
  output logic                           evt_clr_o,
  output logic                           cyc_clr_o,
  output logic [NUM_EVT-1:0]             evt_wr_o,
  output logic                           cyc_wr_lo_o,
  output logic                           cyc_wr_hi_o,
  output logic [NUM_EVT-1:0]             swinc_o,
  output logic [DATA_W-1:0]              rdata_o,
  output logic                           err_o,
  output logic                           irq_o
);
  localparam logic [DATA_W-1:0] IMPL      = 32'h8000_0000 | ((32'h1 << NUM_EVT) - 32'h1);
  localparam logic [6:0]        CTRL_KEEP = 7'b111_1001;
  localparam logic [4:0]        N_FIELD   = 5'(NUM_EVT);

  logic [6:0]                     ctrl_q;
  logic [DATA_W-1:0]              cnten_q, inten_q, ovf_q, rdata_q, rd_mux, ovf_clr;
  logic [3:0]                     usren_q;
  logic [NUM_EVT-1:0][DATA_W-1:0] type_q;
  logic                           err_q, irq_q;
  logic                           is_cnt, is_cyc, is_sw, allow, wr_ok, rd_ok;

  always_comb begin
    is_cnt = 1'b0;
    for (int i = 0; i < NUM_EVT; i++)
      if (bus_addr_i == A_CNT0 + ADDR_W'(i)) is_cnt = 1'b1;
  end

  assign is_cyc = (bus_addr_i == A_CYCLO) || (bus_addr_i == A_CYCHI);
  assign is_sw  = (bus_addr_i == A_SWINC);
  assign allow  = (bus_lvl_i != 2'd0) || usren_q[0]
                || (bus_we_i && is_sw && usren_q[1])
                || (!bus_we_i && is_cyc && usren_q[2])
                || (!bus_we_i && is_cnt && usren_q[3]);
  assign wr_ok  = bus_en_i & bus_we_i & allow;
  assign rd_ok  = bus_en_i & ~bus_we_i & allow;

  assign evt_clr_o   = wr_ok && (bus_addr_i == A_CTRL) && bus_wdata_i[1];
  assign cyc_clr_o   = wr_ok && (bus_addr_i == A_CTRL) && bus_wdata_i[2];
  assign cyc_wr_lo_o = wr_ok && (bus_addr_i == A_CYCLO);
  assign cyc_wr_hi_o = wr_ok && (bus_addr_i == A_CYCHI);
  assign swinc_o     = (wr_ok && is_sw) ? bus_wdata_i[NUM_EVT-1:0] : '0;
  assign ovf_clr     = (wr_ok && (bus_addr_i == A_OVF)) ? bus_wdata_i : '0;

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++)
      evt_wr_o[i] = wr_ok && (bus_addr_i == A_CNT0 + ADDR_W'(i));
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      A_CTRL:  rd_mux = {16'h0, N_FIELD, 4'h0, ctrl_q};
      A_CNTEN: rd_mux = cnten_q;
      A_INTEN: rd_mux = inten_q;
      A_OVF:   rd_mux = ovf_q;
      A_USREN: rd_mux = {28'h0, usren_q};
      A_CYCLO: rd_mux = cyc_val_i[DATA_W-1:0];
      A_CYCHI: rd_mux = cyc_val_i[2*DATA_W-1:DATA_W];
      default: rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_EVT; i++) begin
      if (bus_addr_i == A_TYPE0 + ADDR_W'(i)) rd_mux = type_q[i];
      if (bus_addr_i == A_CNT0 + ADDR_W'(i))  rd_mux = evt_val_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cnten_q <= '0;
      inten_q <= '0;
      ovf_q   <= '0;
      usren_q <= '0;
      type_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      err_q   <= bus_en_i & ~allow;
      irq_q   <= |(ovf_q & inten_q);
      ovf_q   <= (ovf_q & ~ovf_clr) | (ovf_set_i & IMPL);
      rdata_q <= rd_ok ? rd_mux : '0;
      if (wr_ok) begin
        case (bus_addr_i)
          A_CTRL:  ctrl_q  <= bus_wdata_i[6:0] & CTRL_KEEP;
          A_CNTEN: cnten_q <= bus_wdata_i & IMPL;
          A_INTEN: inten_q <= bus_wdata_i & IMPL;
          A_USREN: usren_q <= bus_wdata_i[3:0];
          default: ;
        endcase
      end
      for (int i = 0; i < NUM_EVT; i++)
        if (wr_ok && (bus_addr_i == A_TYPE0 + ADDR_W'(i)))
          type_q[i] <= bus_wdata_i & TYPE_KEEP;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign cnten_o = cnten_q;
  assign type_o  = type_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;
  assign irq_o   = irq_q;

  // R12
  deny_zero_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (rdata_q == '0));

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovf_set_i & IMPL) != '0) |=> ((ovf_q & $past(ovf_set_i & IMPL)) == $past(ovf_set_i & IMPL)));
endmodule

// File: rtl/pmu_core.sv
module pmu_core
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic [1:0]        bus_lvl_i,
  input  logic [3:0]        evt_stb_i,
  input  logic [1:0]        evt_lvl_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic              irq_o
);
  localparam int CYC_BIT = DATA_W - 1;

  logic [6:0]                     ctrl;
  logic [DATA_W-1:0]              cnten, ovf_set;
  logic [NUM_EVT-1:0][DATA_W-1:0] types, evt_val;
  logic [NUM_EVT-1:0]             evt_wr, swinc, evt_wrap;
  logic                           evt_clr, cyc_clr, cyc_wr_lo, cyc_wr_hi, cyc_wrap;
  logic [2*DATA_W-1:0]            cyc_val;

  pmu_regbus #(.NUM_EVT(NUM_EVT)) regs_i (
    .clk(clk), .rst(rst),
    .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_lvl_i(bus_lvl_i),
    .evt_val_i(evt_val), .cyc_val_i(cyc_val), .ovf_set_i(ovf_set),
    .ctrl_o(ctrl), .cnten_o(cnten), .type_o(types),
    .evt_clr_o(evt_clr), .cyc_clr_o(cyc_clr), .evt_wr_o(evt_wr),
    .cyc_wr_lo_o(cyc_wr_lo), .cyc_wr_hi_o(cyc_wr_hi), .swinc_o(swinc),
    .rdata_o(rdata_o), .err_o(err_o), .irq_o(irq_o)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    pmu_evt_counter #(.CNT_W(DATA_W)) cnt_i (
      .clk(clk), .rst(rst),
      .en_i(ctrl[0] & cnten[g]),
      .type_i(types[g]), .stb_i(evt_stb_i), .lvl_i(evt_lvl_i), .sw_i(swinc[g]),
      .clr_i(evt_clr), .wr_i(evt_wr[g]), .wdata_i(bus_wdata_i),
      .val_o(evt_val[g]), .wrap_o(evt_wrap[g])
    );
  end

  pmu_cyc_counter #(.CYC_W(2*DATA_W), .PRE_W(6)) cyc_i (
    .clk(clk), .rst(rst),
    .en_i(ctrl[0] & cnten[CYC_BIT]), .div_i(ctrl[3]), .long_i(ctrl[6]),
    .clr_i(cyc_clr), .wr_lo_i(cyc_wr_lo), .wr_hi_i(cyc_wr_hi), .wdata_i(bus_wdata_i),
    .val_o(cyc_val), .wrap_o(cyc_wrap)
  );

  always_comb begin
    ovf_set                = '0;
    ovf_set[NUM_EVT-1:0]   = evt_wrap;
    ovf_set[CYC_BIT]       = cyc_wrap;
  end
endmodule

// File: tb/pmu_core_tb_top.sv
module pmu_core_tb_top;
  import pmu_pkg::*;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_lvl = 2'd1;
  logic [3:0]  evt_stb = '0;
  logic [1:0]  evt_lvl = 2'd3;
  logic [31:0] rdata;
  logic        err, irq;

  int errs = 0;
  int checks = 0;

  pmu_core #(.NUM_EVT(N)) dut_i (
    .clk(clk), .rst(rst), .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_lvl_i(bus_lvl), .evt_stb_i(evt_stb), .evt_lvl_i(evt_lvl),
    .rdata_o(rdata), .err_o(err), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] l);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_lvl = l;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, input logic [1:0] l, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_lvl = l;
    @(negedge clk);
    d = rdata; e = err;
    bus_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // bench view of whether one cycle's stimulus bumps a counter of type t
  function automatic bit model_hit(input bit [31:0] t, input bit [3:0] s, input bit [1:0] l);
    bit lvl_pass, ev;
    lvl_pass = (l == 2'd0 && !t[30]) || (l == 2'd1 && !t[31]) || (l == 2'd2 && t[27]);
    ev = (t[15:0] == 16'h0003 && s[0]) || (t[15:0] == 16'h0004 && s[1]) ||
         (t[15:0] == 16'h0010 && s[2]) || (t[15:0] == 16'h0012 && s[3]) ||
         (t[15:0] == 16'h0011);
    return lvl_pass && ev;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic        e;
    bit [15:0]   codes [7];
    bit [31:0]   tp [N];
    bit [31:0]   cm [N];
    bit [31:0]   en_bits;
    codes = '{16'h0000, 16'h0003, 16'h0004, 16'h0010, 16'h0011, 16'h0012, 16'h0055};
    void'($urandom(32'd20240611));

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 irq", {63'h0, irq}, 64'h0);
    check("R1 err", {63'h0, err}, 64'h0);
    brd(A_CTRL, 2'd1, d, e);  check("R1 ctrl", {32'h0, d}, 64'h2000);
    brd(A_CNTEN, 2'd1, d, e); check("R1 cnten", {32'h0, d}, 64'h0);
    brd(A_OVF, 2'd1, d, e);   check("R1 ovf", {32'h0, d}, 64'h0);
    brd(A_CNT0, 2'd1, d, e);  check("R1 cnt0", {32'h0, d}, 64'h0);
    brd(A_CYCLO, 2'd1, d, e); check("R1 cyc", {32'h0, d}, 64'h0);

    // R2 control mask
    bwr(A_CTRL, 32'hFFFF_FFFF, 2'd1);
    brd(A_CTRL, 2'd1, d, e);  check("R2 ctrl mask", {32'h0, d}, 64'h2079);
    bwr(A_CTRL, 32'h0, 2'd1);

    // R5 type mask, R13 unmapped
    bwr(A_TYPE0 + 8'd1, 32'hFFFF_FFFF, 2'd1);
    brd(A_TYPE0 + 8'd1, 2'd1, d, e); check("R5 type mask", {32'h0, d}, 64'hC800_FFFF);
    brd(A_TYPE0 + 8'd5, 2'd1, d, e); check("R13 unmapped type", {32'h0, d}, 64'h0);
    brd(A_CNT0 + 8'd4, 2'd1, d, e);  check("R13 unmapped cnt", {32'h0, d}, 64'h0);
    brd(8'h30, 2'd1, d, e);          check("R13 hole", {32'h0, d}, 64'h0);

    // R3 R4 random bursts against the model
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) begin
        tp[i] = ($urandom & 32'hC800_0000) | {16'h0, codes[$urandom % 7]};
        bwr(A_TYPE0 + 8'(i), tp[i], 2'd1);
        cm[i] = 0;
      end
      en_bits = (r == 0) ? 32'hF : ($urandom & 32'hF);
      bwr(A_CNTEN, en_bits, 2'd1);
      bwr(A_CTRL, 32'h3, 2'd1);
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        evt_stb = 4'($urandom);
        evt_lvl = 2'($urandom % 3);
        for (int i = 0; i < N; i++)
          if (en_bits[i] && model_hit(tp[i], evt_stb, evt_lvl)) cm[i]++;
      end
      @(negedge clk);
      evt_stb = '0; evt_lvl = 2'd3;
      for (int i = 0; i < N; i++) begin
        brd(A_CNT0 + 8'(i), 2'd1, d, e);
        check($sformatf("R3 R4 round %0d counter %0d", r, i), {32'h0, d}, {32'h0, cm[i]});
      end
    end

    // R7 event counter clear
    bwr(A_CTRL, 32'h3, 2'd1);
    for (int i = 0; i < N; i++) begin
      brd(A_CNT0 + 8'(i), 2'd1, d, e);
      check("R7 event clear", {32'h0, d}, 64'h0);
    end

    // R6 software increment
    bwr(A_TYPE0 + 8'd2, 32'h0, 2'd1);
    bwr(A_CNTEN, 32'h4, 2'd1);
    bwr(A_CTRL, 32'h3, 2'd1);
    bwr(A_SWINC, 32'h4, 2'd1);
    bwr(A_SWINC, 32'h5, 2'd1);
    brd(A_CNT0 + 8'd2, 2'd1, d, e); check("R6 swinc", {32'h0, d}, 64'h2);
    bwr(A_USREN, 32'h8, 2'd1);
    bwr(A_SWINC, 32'h4, 2'd0);
    brd(A_CNT0 + 8'd2, 2'd1, d, e); check("R12 denied swinc", {32'h0, d}, 64'h2);
    bwr(A_USREN, 32'h2, 2'd1);
    bwr(A_SWINC, 32'h4, 2'd0);
    brd(A_CNT0 + 8'd2, 2'd1, d, e); check("R6 R12 level0 swinc", {32'h0, d}, 64'h3);

    // R10 R11 event overflow and interrupt
    bwr(A_TYPE0, 32'h0000_0003, 2'd1);
    bwr(A_CNTEN, 32'h1, 2'd1);
    bwr(A_CNT0, 32'hFFFF_FFFF, 2'd1);
    bwr(A_OVF, 32'hFFFF_FFFF, 2'd1);
    @(negedge clk); evt_stb = 4'h1; evt_lvl = 2'd1;
    @(negedge clk); evt_stb = 4'h0; evt_lvl = 2'd3;
    brd(A_CNT0, 2'd1, d, e); check("R10 wrap value", {32'h0, d}, 64'h0);
    brd(A_OVF, 2'd1, d, e);  check("R10 flag set", {32'h0, d}, 64'h1);
    check("R11 irq masked", {63'h0, irq}, 64'h0);
    bwr(A_INTEN, 32'h1, 2'd1);
    idle(2);
    check("R11 irq high", {63'h0, irq}, 64'h1);
    bwr(A_OVF, 32'h1, 2'd1);
    idle(2);
    check("R11 irq low", {63'h0, irq}, 64'h0);
    brd(A_OVF, 2'd1, d, e);  check("R10 w1c", {32'h0, d}, 64'h0);

    // R8 R9 cycle counter
    bwr(A_CNTEN, 32'h0, 2'd1);
    bwr(A_CTRL, 32'h5, 2'd1);
    bwr(A_CNTEN, 32'h8000_0000, 2'd1);
    idle(10);
    bwr(A_CNTEN, 32'h0, 2'd1);
    brd(A_CYCLO, 2'd1, d, e); check("R8 plain count", {32'h0, d}, 64'd12);

    bwr(A_CYCLO, 32'hFFFF_FFFF, 2'd1);
    bwr(A_CYCHI, 32'h0, 2'd1);
    bwr(A_OVF, 32'hFFFF_FFFF, 2'd1);
    bwr(A_CNTEN, 32'h8000_0000, 2'd1);
    bwr(A_CNTEN, 32'h0, 2'd1);
    brd(A_CYCLO, 2'd1, d, e); brd(A_CYCHI, 2'd1, d2, e);
    check("R9 short carry", {d2, d}, 64'h1_0000_0001);
    brd(A_OVF, 2'd1, d, e); check("R9 short flag", {32'h0, d}, 64'h8000_0000);

    bwr(A_OVF, 32'hFFFF_FFFF, 2'd1);
    bwr(A_CTRL, 32'h41, 2'd1);
    bwr(A_CYCLO, 32'hFFFF_FFFF, 2'd1);
    bwr(A_CYCHI, 32'h0, 2'd1);
    bwr(A_CNTEN, 32'h8000_0000, 2'd1);
    bwr(A_CNTEN, 32'h0, 2'd1);
    brd(A_OVF, 2'd1, d, e); check("R9 long no flag", {32'h0, d}, 64'h0);
    bwr(A_CYCHI, 32'hFFFF_FFFF, 2'd1);
    bwr(A_CYCLO, 32'hFFFF_FFFF, 2'd1);
    bwr(A_CNTEN, 32'h8000_0000, 2'd1);
    bwr(A_CNTEN, 32'h0, 2'd1);
    brd(A_CYCLO, 2'd1, d, e); brd(A_CYCHI, 2'd1, d2, e);
    check("R9 long wrap value", {d2, d}, 64'h1);
    brd(A_OVF, 2'd1, d, e); check("R9 long flag", {32'h0, d}, 64'h8000_0000);

    bwr(A_CTRL, 32'h0D, 2'd1);
    brd(A_CYCLO, 2'd1, d, e); check("R7 cycle clear", {32'h0, d}, 64'h0);
    bwr(A_CNTEN, 32'h8000_0000, 2'd1);
    idle(128);
    bwr(A_CNTEN, 32'h0, 2'd1);
    bwr(A_USREN, 32'h4, 2'd1);
    brd(A_CYCLO, 2'd0, d, e);
    check("R8 divide by 64", {32'h0, d}, 64'h2);
    check("R12 cycle read allowed", {63'h0, e}, 64'h0);

    // R12 access control
    bwr(A_USREN, 32'h0, 2'd1);
    brd(A_CTRL, 2'd0, d, e);
    check("R12 denied read data", {32'h0, d}, 64'h0);
    check("R12 denied read err", {63'h0, e}, 64'h1);
    @(negedge clk);
    check("R12 err one cycle", {63'h0, err}, 64'h0);
    bwr(A_USREN, 32'h8, 2'd1);
    brd(A_CNT0 + 8'd2, 2'd0, d, e);
    check("R12 counter read allowed", {32'h0, d}, 64'h3);
    brd(A_CYCLO, 2'd0, d, e);
    check("R12 cycle read denied", {31'h0, e, d}, 64'h1_0000_0000);
    bwr(A_CTRL, 32'h0, 2'd0);
    brd(A_CTRL, 2'd1, d, e); check("R12 denied write", {32'h0, d}, 64'h2009);
    bwr(A_USREN, 32'h1, 2'd1);
    brd(A_CTRL, 2'd0, d, e); check("R12 full access", {32'h0, d}, 64'h2009);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule